// File: doc/BRIEF.md
# Interrupt Level Merger and Router

This block combines an encoded interrupt priority level, which arrives as three active-low lines, with one extra active-low request from an expansion slot. The slot request sits at level 6 and outranks everything else, including the other level-6 sources that share the incoming chained line. Every asynchronous input is brought into the clock domain through a synchronizer. The merged result is then decoded into a 3-bit level code.

A routing select picks the processor that serves interrupts. With the select low, the primary processor receives the merged level as an active-low IPL code. With the select high, the primary lines are parked at the idle code and a secondary processor instead receives a single active-low, level-style interrupt line. The secondary processor reads the pending level through a small read port. The port returns only a level code, never a vector, and reading it changes nothing.

Top module: `irq_level_router`

## Requirements
- R1: After reset the level code reads 000, `prim_ipl_n_o` is 3'b111, `sec_irq_n_o` is 1 and `rd_data_o` is all zeros.
- R2: While `slot_irq_n_i` is 0, the level code is 3'b111 and the merged primary code is 3'b001 (level 6), whatever the incoming lines carry.
- R3: Incoming level L is presented as `ipl_n_i` = ~L. When the slot request is idle, level 6 gives code 110, level 5 gives 101, level 4 gives 100 and level 2 gives 010. The merged primary code equals `ipl_n_i` for these four levels.
- R4: With `ipl_n_i` = 3'b111 and the slot request idle, the code is 000, the merged primary code is 3'b111 and `sec_irq_n_o` is 1.
- R5: Incoming levels 1, 3 and 7 (`ipl_n_i` = 110, 100, 000) are ignored when the slot request is idle. The code is 000, the merged primary code is 3'b111 and `sec_irq_n_o` stays 1.
- R6: With `route_sel_i` = 1, `sec_irq_n_o` is 0 exactly when the level code is nonzero.
- R7: With `route_sel_i` = 1, `prim_ipl_n_o` is held at 3'b111.
- R8: With `route_sel_i` = 0, `sec_irq_n_o` is 1 and `prim_ipl_n_o` carries the merged primary code.
- R9: A change on `ipl_n_i` or `slot_irq_n_i` reaches the outputs on the third rising edge after it: two synchronizer stages, then one output register. A change on `route_sel_i` reaches the outputs on the first rising edge.
- R10: When `rd_en_i` is 1 at a rising edge, `rd_data_o` takes the level code in bits [2:0] with zeros above. Otherwise `rd_data_o` holds its value. Reading does not alter the level code, `prim_ipl_n_o` or `sec_irq_n_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ipl_n_i | input | 3 | Incoming encoded level, active low, asynchronous |
| slot_irq_n_i | input | 1 | Expansion slot request, active low, asynchronous |
| route_sel_i | input | 1 | 0 routes to the primary processor, 1 to the secondary |
| rd_en_i | input | 1 | Read strobe for the level register |
| rd_data_o | output | DATA_W | Read data: level code in bits [2:0], zeros above |
| prim_ipl_n_o | output | 3 | Merged active-low IPL code to the primary processor |
| sec_irq_n_o | output | 1 | Active-low interrupt line to the secondary processor |

## Verification
Each supported incoming level is driven alone. This shows that every level maps to its own code and that level 6 from the chained line gives 110 rather than the slot's 111. The unsupported levels 1, 3 and 7 are driven next, to show that they are masked rather than passed through. The slot request is then combined with an idle level, with a lower level and with level 6, which shows that it wins over every other source. The whole set is repeated under both routing selects to confirm which output carries the request, and directed cases pin down the three-edge latency and show that repeated reads leave the state unchanged.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;
    localparam int LVL_W = 3;
    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t CODE_NONE  = 3'b000;
    localparam lvl_t CODE_SLOT  = 3'b111;
    localparam lvl_t CODE_L6    = 3'b110;
    localparam lvl_t CODE_L5    = 3'b101;
    localparam lvl_t CODE_L4    = 3'b100;
    localparam lvl_t CODE_L2    = 3'b010;
    localparam lvl_t SLOT_LEVEL = 3'd6;
    localparam lvl_t IPL_IDLE_N = 3'b111;

    typedef struct packed {
        lvl_t level;
        lvl_t prim_ipl_n;
        logic sec_irq_n;
    } route_state_t;

    localparam route_state_t ROUTE_RESET = '{
        level:      CODE_NONE,
        prim_ipl_n: IPL_IDLE_N,
        sec_irq_n:  1'b1
    };
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int             WIDTH     = 4,
    parameter int             STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_prio_decode.sv
module irq_prio_decode
    import irq_merge_pkg::*;
(
    input  lvl_t ipl_n_i,
    input  logic slot_n_i,
    output lvl_t code_o,
    output lvl_t merged_ipl_n_o,
    output logic pending_o
);
    lvl_t level_in;
    lvl_t chain_code;

    assign level_in = ~ipl_n_i;

    always_comb begin
        unique case (level_in)
            3'd6:    chain_code = CODE_L6;
            3'd5:    chain_code = CODE_L5;
            3'd4:    chain_code = CODE_L4;
            3'd2:    chain_code = CODE_L2;
            default: chain_code = CODE_NONE;
        endcase
    end

    always_comb begin
        if (!slot_n_i) begin
            code_o         = CODE_SLOT;
            merged_ipl_n_o = ~SLOT_LEVEL;
        end else if (chain_code != CODE_NONE) begin
            code_o         = chain_code;
            merged_ipl_n_o = ipl_n_i;
        end else begin
            code_o         = CODE_NONE;
            merged_ipl_n_o = IPL_IDLE_N;
        end
        pending_o = (code_o != CODE_NONE);
    end
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
    import irq_merge_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  lvl_t              level_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int PAD_W = DATA_W - LVL_W;

    logic [DATA_W-1:0] rd_data_d, rd_data_q;

    always_comb begin
        rd_data_d = rd_data_q;
        if (rd_en_i) begin
            rd_data_d = {{PAD_W{1'b0}}, level_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else begin
            rd_data_q <= rd_data_d;
        end
    end

    assign rd_data_o = rd_data_q;

    assert_read_returns_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_data_o == {{PAD_W{1'b0}}, $past(level_i)});

    assert_read_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/irq_level_router.sv
module irq_level_router
    import irq_merge_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        ipl_n_i,
    input  logic              slot_irq_n_i,
    input  logic              route_sel_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [2:0]        prim_ipl_n_o,
    output logic              sec_irq_n_o
);
    localparam int SYNC_W = LVL_W + 1;

    logic [SYNC_W-1:0] sync_bus;
    lvl_t ipl_n_s;
    logic slot_n_s;
    lvl_t code;
    lvl_t merged_ipl_n;
    logic pending;

    route_state_t st_d, st_q;

    irq_sync #(
        .WIDTH     (SYNC_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ({SYNC_W{1'b1}})
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({slot_irq_n_i, ipl_n_i}),
        .sync_o  (sync_bus)
    );

    assign ipl_n_s  = sync_bus[LVL_W-1:0];
    assign slot_n_s = sync_bus[LVL_W];

    irq_prio_decode u_decode (
        .ipl_n_i        (ipl_n_s),
        .slot_n_i       (slot_n_s),
        .code_o         (code),
        .merged_ipl_n_o (merged_ipl_n),
        .pending_o      (pending)
    );

    always_comb begin
        st_d            = st_q;
        st_d.level      = code;
        st_d.prim_ipl_n = route_sel_i ? IPL_IDLE_N : merged_ipl_n;
        st_d.sec_irq_n  = ~(route_sel_i & pending);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ROUTE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    irq_read_port #(
        .DATA_W (DATA_W)
    ) u_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en_i),
        .level_i   (st_q.level),
        .rd_data_o (rd_data_o)
    );

    assign prim_ipl_n_o = st_q.prim_ipl_n;
    assign sec_irq_n_o  = st_q.sec_irq_n;

    assert_slot_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_n_s |=> st_q.level == CODE_SLOT);

    assert_no_unsupported_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.level != 3'b001 && st_q.level != 3'b011);

    assert_sec_needs_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_irq_n_o |-> st_q.level != CODE_NONE);

    assert_prim_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        route_sel_i |=> prim_ipl_n_o == IPL_IDLE_N);

    assert_sec_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !route_sel_i |=> sec_irq_n_o);
endmodule

// File: tb/irq_level_router_tb.sv
module irq_level_router_tb;
    localparam int DATA_W = 8;
    localparam int NVEC   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        ipl_n_i = 3'b111;
    logic              slot_irq_n_i = 1'b1;
    logic              route_sel_i = 1'b0;
    logic              rd_en_i = 1'b0;
    logic [DATA_W-1:0] rd_data_o;
    logic [2:0]        prim_ipl_n_o;
    logic              sec_irq_n_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_level_router #(.DATA_W(DATA_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ipl_n_i      (ipl_n_i),
        .slot_irq_n_i (slot_irq_n_i),
        .route_sel_i  (route_sel_i),
        .rd_en_i      (rd_en_i),
        .rd_data_o    (rd_data_o),
        .prim_ipl_n_o (prim_ipl_n_o),
        .sec_irq_n_o  (sec_irq_n_o)
    );

    // {route, ipl_n, slot_n, exp_code, exp_prim_n, exp_sec_n}
    localparam logic [11:0] VEC [NVEC] = '{
        {1'b0, 3'b111, 1'b1, 3'b000, 3'b111, 1'b1},
        {1'b0, 3'b001, 1'b1, 3'b110, 3'b001, 1'b1},
        {1'b0, 3'b010, 1'b1, 3'b101, 3'b010, 1'b1},
        {1'b0, 3'b011, 1'b1, 3'b100, 3'b011, 1'b1},
        {1'b0, 3'b101, 1'b1, 3'b010, 3'b101, 1'b1},
        {1'b0, 3'b110, 1'b1, 3'b000, 3'b111, 1'b1},
        {1'b0, 3'b100, 1'b1, 3'b000, 3'b111, 1'b1},
        {1'b0, 3'b000, 1'b1, 3'b000, 3'b111, 1'b1},
        {1'b0, 3'b111, 1'b0, 3'b111, 3'b001, 1'b1},
        {1'b0, 3'b010, 1'b0, 3'b111, 3'b001, 1'b1},
        {1'b1, 3'b010, 1'b1, 3'b101, 3'b111, 1'b0},
        {1'b1, 3'b101, 1'b1, 3'b010, 3'b111, 1'b0},
        {1'b1, 3'b111, 1'b0, 3'b111, 3'b111, 1'b0},
        {1'b1, 3'b001, 1'b0, 3'b111, 3'b111, 1'b0},
        {1'b1, 3'b110, 1'b1, 3'b000, 3'b111, 1'b1},
        {1'b1, 3'b111, 1'b1, 3'b000, 3'b111, 1'b1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic read_level();
        rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held and just after release
        chk("R1 rd_data", int'(rd_data_o), 0);
        chk("R1 prim", int'(prim_ipl_n_o), 7);
        chk("R1 sec", int'(sec_irq_n_o), 1);
        rst_n = 1'b1;
        @(negedge clk);
        read_level();
        chk("R1 level after reset", int'(rd_data_o), 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [11:0] v;
            string ctag, rtag;
            v = VEC[i];
            route_sel_i  = v[11];
            ipl_n_i      = v[10:8];
            slot_irq_n_i = v[7];
            if (!v[7])                  ctag = "R2";
            else if (v[6:4] != 3'b000)  ctag = "R3";
            else if (v[10:8] == 3'b111) ctag = "R4";
            else                        ctag = "R5";
            rtag = v[11] ? "R6/R7" : "R8";
            repeat (4) @(negedge clk);
            read_level();
            chk($sformatf("%s vec%0d code", ctag, i), int'(rd_data_o), int'(v[6:4]));
            chk($sformatf("%s vec%0d prim", rtag, i), int'(prim_ipl_n_o), int'(v[3:1]));
            chk($sformatf("%s vec%0d sec", rtag, i), int'(sec_irq_n_o), int'(v[0]));
        end

        // R9: input latency of three edges
        route_sel_i = 1'b0; ipl_n_i = 3'b111; slot_irq_n_i = 1'b1;
        repeat (4) @(negedge clk);
        ipl_n_i = 3'b011;
        repeat (2) @(negedge clk);
        chk("R9 prim before third edge", int'(prim_ipl_n_o), 7);
        @(negedge clk);
        chk("R9 prim at third edge", int'(prim_ipl_n_o), 3);
        slot_irq_n_i = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 slot before third edge", int'(prim_ipl_n_o), 3);
        @(negedge clk);
        chk("R9 slot at third edge", int'(prim_ipl_n_o), 1);

        // R9: routing select latency of one edge
        route_sel_i = 1'b1;
        @(negedge clk);
        chk("R9 route prim", int'(prim_ipl_n_o), 7);
        chk("R9 route sec", int'(sec_irq_n_o), 0);

        // R10: holds without strobe, reads leave state unchanged
        read_level();
        chk("R10 read slot code", int'(rd_data_o), 7);
        slot_irq_n_i = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 hold without strobe", int'(rd_data_o), 7);
        read_level();
        read_level();
        chk("R10 repeated read", int'(rd_data_o), 4);
        chk("R10 upper bits zero", int'(rd_data_o[DATA_W-1:3]), 0);
        chk("R10 sec unchanged by read", int'(sec_irq_n_o), 0);
        chk("R10 prim unchanged by read", int'(prim_ipl_n_o), 7);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule